// File: doc/BRIEF.md
# Prioritized Interrupt Controller Core

This block collects interrupt requests for a single processor. It takes a parameterized number of external request lines and four software-triggered inter-processor channels, and drives one interrupt-request line. Each channel has a configuration word with these fields: a vector, a 4-bit priority, a level/edge select, an active-polarity select and a mask. The processor reads an acknowledge register to learn which vector to service. It writes an end-of-interrupt register when it has finished. A task-priority register sets the level below which requests are held off.

An acknowledge pushes the priority it serves onto an in-service stack. A request is presented only when its priority is above both the task priority and the top of that stack, so nesting is strictly by priority. An end-of-interrupt write pops the stack. Edge requests stay latched while other work is in service. A global configuration register can return every channel to its default configuration. Its reset bit clears itself after a fixed number of cycles.

Top module: `prio_intc`

## Requirements
- R1: After reset, external source s reads 0x8000_0000 | s, IPI channel i reads 0x8000_0000 | (NUM_SRC+i), the task priority reads 15, the spurious vector reads 0xFF, irq_out is low and the who-am-I word reads 0.
- R2: A channel configuration word has the vector in bits 7:0, the priority in bits 11:8, polarity in bit 16 (1 = active high), sense in bit 17 (1 = level) and the mask in bit 31. A read issued right after a write returns the written fields, including the new mask.
- R3: A level source is pending while its registered input equals the active level selected by bit 16. The pending state follows the input one clock edge after the input changes.
- R4: An edge source latches on an inactive-to-active transition and stays pending after the input returns. An acknowledge of that source clears the latch. An edge that arrives while the source is in service is held and presented after end-of-interrupt.
- R5: irq_out is high only if the best eligible priority is greater than the task priority. A task priority of 15 blocks everything, and a task priority of 0 passes any priority of 1 or more.
- R6: The highest priority wins. Among equal priorities the lowest channel index wins, and the IPI channels (indices 0..3) rank above the external sources.
- R7: A read of the acknowledge register (0x084) returns the winning vector and pushes its priority only when that priority exceeds both the task priority and the in-service top. Otherwise it returns the spurious vector register (0x008) and changes nothing.
- R8: A write of any value to the end-of-interrupt register (0x088) pops the in-service stack.
- R9: A masked channel is never presented, but its edge latch is kept and is delivered once the channel is unmasked.
- R10: A write to IPI dispatch register i (0x0C0 + 0x10*i) makes IPI i pending only when bit 0 of the data is 1.
- R11: Writing 1 to bit 0 of the global configuration register (0x004) sets that bit. It reads 1 for RESET_CYCLES cycles and then clears itself, and every channel returns to its reset configuration.
- R12: The feature word (0x000) holds the version code in bits 31:24, the last CPU index (0) in bits 23:16 and NUM_SRC-1 in bits 15:0.
- R13: Bit 30 of a configuration word reads 1 while that channel is pending, whether or not it is masked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | NUM_SRC | External request lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (acknowledge side effect) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current state |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Read data is combinational, so the bench samples it in the cycle that carries the read strobe. Side effects of reads and writes appear at the next falling edge after the clock edge that takes the strobe. A change on src_in shows on irq_out one rising edge later, for both level and edge sources. The bench therefore changes inputs on a falling edge, lets one rising edge pass, and samples on the falling edge that follows. Each expected vector and irq_out level is derived from the programmed priorities, the task priority and the priorities the bench itself has pushed by acknowledging.

// File: rtl/intc_pkg.sv
package intc_pkg;

   localparam int unsigned IPI_COUNT = 4;
   localparam int unsigned PRIO_W    = 4;

   // byte addresses
   localparam logic [31:0] A_FEAT  = 32'h000;
   localparam logic [31:0] A_GCONF = 32'h004;
   localparam logic [31:0] A_SPUR  = 32'h008;
   localparam logic [31:0] A_IPIVP = 32'h010;
   localparam logic [31:0] A_TASK  = 32'h080;
   localparam logic [31:0] A_ACK   = 32'h084;
   localparam logic [31:0] A_EOI   = 32'h088;
   localparam logic [31:0] A_WHO   = 32'h08C;
   localparam logic [31:0] A_DISP  = 32'h0C0;
   localparam logic [31:0] A_SRC   = 32'h100;

   typedef struct packed {
      logic              mask;
      logic              level;
      logic              act_hi;
      logic [PRIO_W-1:0] prio;
      logic [7:0]        vec;
   } chan_cfg_t;

   function automatic logic [31:0] pack_cfg(chan_cfg_t c, logic active);
      logic [31:0] w;
      w       = '0;
      w[31]   = c.mask;
      w[30]   = active;
      w[17]   = c.level;
      w[16]   = c.act_hi;
      w[11:8] = c.prio;
      w[7:0]  = c.vec;
      return w;
   endfunction

   function automatic chan_cfg_t unpack_cfg(logic [31:0] w);
      chan_cfg_t c;
      c.mask   = w[31];
      c.level  = w[17];
      c.act_hi = w[16];
      c.prio   = w[11:8];
      c.vec    = w[7:0];
      return c;
   endfunction

endpackage

// File: rtl/intc_channel.sv
module intc_channel
   import intc_pkg::*;
#(
   parameter bit         IS_IPI  = 1'b0,
   parameter logic [7:0] RST_VEC = 8'd0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        soft_rst,
   input  logic        cfg_we,
   input  logic [31:0] cfg_wdata,
   input  logic        trig,
   input  logic        ack,
   output chan_cfg_t   cfg,
   output logic        pend
);

   localparam chan_cfg_t RST_CFG = '{mask: 1'b1, level: 1'b0, act_hi: 1'b0,
                                     prio: '0, vec: RST_VEC};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cfg <= RST_CFG;
      else if (soft_rst) cfg <= RST_CFG;
      else if (cfg_we)   cfg <= unpack_cfg(cfg_wdata);
   end

   generate
      if (IS_IPI) begin : g_ipi
         logic latch;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        latch <= 1'b0;
            else if (soft_rst) latch <= 1'b0;
            else if (trig)     latch <= 1'b1;
            else if (ack)      latch <= 1'b0;
         end
         assign pend = latch;
      end else begin : g_ext
         logic in_q, latch, now_act, was_act;
         assign now_act = (trig == cfg.act_hi);
         assign was_act = (in_q == cfg.act_hi);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) in_q <= 1'b0;
            else        in_q <= trig;
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                latch <= 1'b0;
            else if (soft_rst || cfg.level)            latch <= 1'b0;
            else if (now_act && !was_act)              latch <= 1'b1;
            else if (ack)                              latch <= 1'b0;
         end
         assign pend = cfg.level ? was_act : latch;
      end
   endgenerate

   // R2: a written mask is visible on the next cycle
   assert_mask_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && !soft_rst) |=> (cfg.mask == $past(cfg_wdata[31])));

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
   import intc_pkg::*;
#(
   parameter int unsigned NCH = 12,
   localparam int unsigned IW = $clog2(NCH)
) (
   input  logic [NCH-1:0]        elig,
   input  logic [NCH*PRIO_W-1:0] prio_flat,
   output logic                  valid,
   output logic [IW-1:0]         idx,
   output logic [PRIO_W-1:0]     best
);

   always_comb begin
      valid = 1'b0;
      idx   = '0;
      best  = '0;
      // scan downward so that on ties the lower index overwrites
      for (int i = NCH - 1; i >= 0; i--) begin
         if (elig[i] && (!valid || prio_flat[i*PRIO_W +: PRIO_W] >= best)) begin
            valid = 1'b1;
            idx   = IW'(i);
            best  = prio_flat[i*PRIO_W +: PRIO_W];
         end
      end
   end

endmodule

// File: rtl/intc_isr_stack.sv
module intc_isr_stack
   import intc_pkg::*;
#(
   parameter int unsigned DEPTH = 15,
   localparam int unsigned SPW = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic              pop,
   input  logic [PRIO_W-1:0] push_prio,
   output logic [PRIO_W-1:0] top
);

   logic [PRIO_W-1:0] mem [DEPTH];
   logic [SPW-1:0]    sp;
   logic              room;

   assign room = (sp < SPW'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    sp <= '0;
      else if (push && room)         sp <= sp + 1'b1;
      else if (pop && sp != '0)      sp <= sp - 1'b1;
   end

   always_ff @(posedge clk) begin
      if (push && room) mem[sp] <= push_prio;
   end

   assign top = (sp == '0) ? '0 : mem[sp - 1'b1];

   // R7: a push lands on the top
   assert_push_top_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (push && room) |=> (top == $past(push_prio)));
   // R7: strictly rising priorities never exhaust the stack
   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> room);
   // R8: a pop removes exactly one entry
   assert_pop_depth_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push && sp != '0) |=> (sp == $past(sp) - 1'b1));

endmodule

// File: rtl/prio_intc.sv
module prio_intc
   import intc_pkg::*;
#(
   parameter int unsigned NUM_SRC      = 8,
   parameter int unsigned ADDR_W       = 12,
   parameter int unsigned ISR_DEPTH    = 15,
   parameter int unsigned RESET_CYCLES = 4,
   parameter int unsigned VERSION      = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_in,
   input  logic               bus_wr,
   input  logic               bus_rd,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic               irq_out
);

   localparam int unsigned NCH = IPI_COUNT + NUM_SRC;
   localparam int unsigned IW  = $clog2(NCH);
   localparam int unsigned CW  = $clog2(RESET_CYCLES + 1);

   generate
      if (NUM_SRC < 1 || NUM_SRC > 240)
         $error("prio_intc: NUM_SRC out of range");
      if (ADDR_W < 9 || ADDR_W > 31 || (256 + NUM_SRC * 16) > (1 << ADDR_W))
         $error("prio_intc: ADDR_W cannot cover the map");
      if (ISR_DEPTH < 15)
         $error("prio_intc: ISR_DEPTH must hold every priority level");
      if (RESET_CYCLES < 1)
         $error("prio_intc: RESET_CYCLES must be at least 1");
      if (VERSION < 1 || VERSION > 3)
         $error("prio_intc: unknown VERSION code");
   endgenerate

   // ---------------- address decode ----------------
   logic [31:0] au, src_off;
   logic [1:0]  ipi_vp_i, ipi_dp_i;
   logic        ipi_vp_hit, ipi_dp_hit, src_hit;

   assign au         = {{(32 - ADDR_W){1'b0}}, bus_addr};
   assign src_off    = (au - A_SRC) >> 4;
   assign ipi_vp_i   = 2'(((au - A_IPIVP) >> 4));
   assign ipi_dp_i   = au[5:4];
   assign ipi_vp_hit = (au >= A_IPIVP) && (au < A_IPIVP + 32'h40) && (au[3:0] == 4'h0);
   assign ipi_dp_hit = (au >= A_DISP) && (au < A_DISP + 32'h40) && (au[3:0] == 4'h0);
   assign src_hit    = (au >= A_SRC) && (src_off < NUM_SRC) && (au[3:0] == 4'h0);

   // ---------------- global registers ----------------
   logic [CW-1:0]       rst_cnt;
   logic                busy;
   logic [PRIO_W-1:0]   task_q;
   logic [7:0]          spur_q;

   assign busy = (rst_cnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                          rst_cnt <= '0;
      else if (busy)                                       rst_cnt <= rst_cnt - 1'b1;
      else if (bus_wr && au == A_GCONF && bus_wdata[0])    rst_cnt <= CW'(RESET_CYCLES);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         task_q <= '1;
         spur_q <= 8'hFF;
      end else if (bus_wr) begin
         if (au == A_TASK) task_q <= bus_wdata[PRIO_W-1:0];
         if (au == A_SPUR) spur_q <= bus_wdata[7:0];
      end
   end

   // ---------------- channels ----------------
   chan_cfg_t             cfg_a [NCH];
   logic [NCH-1:0]        pend_v, mask_v, ack_v;
   logic [NCH*PRIO_W-1:0] prio_flat;
   logic                  best_valid, qualify, take;
   logic [IW-1:0]         best_idx;
   logic [PRIO_W-1:0]     best_prio, isr_top;

   generate
      for (genvar c = 0; c < NCH; c++) begin : g_ch
         logic we, trig;
         if (c < IPI_COUNT) begin : g_ipi_ch
            assign we   = bus_wr && ipi_vp_hit && (ipi_vp_i == 2'(c));
            assign trig = bus_wr && ipi_dp_hit && (ipi_dp_i == 2'(c)) && bus_wdata[0] && !busy;
         end else begin : g_ext_ch
            assign we   = bus_wr && src_hit && (src_off == 32'(c - IPI_COUNT));
            assign trig = src_in[c - IPI_COUNT];
         end
         intc_channel #(
            .IS_IPI  (c < IPI_COUNT),
            .RST_VEC ((c < IPI_COUNT) ? 8'(NUM_SRC + c) : 8'(c - IPI_COUNT))
         ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .soft_rst  (busy),
            .cfg_we    (we),
            .cfg_wdata (bus_wdata),
            .trig      (trig),
            .ack       (ack_v[c]),
            .cfg       (cfg_a[c]),
            .pend      (pend_v[c])
         );
         assign mask_v[c]                    = cfg_a[c].mask;
         assign prio_flat[c*PRIO_W +: PRIO_W] = cfg_a[c].prio;
         assign ack_v[c]                     = take && (best_idx == IW'(c));
      end
   endgenerate

   intc_arbiter #(.NCH(NCH)) u_arb (
      .elig      (pend_v & ~mask_v),
      .prio_flat (prio_flat),
      .valid     (best_valid),
      .idx       (best_idx),
      .best      (best_prio)
   );

   assign qualify = best_valid && (best_prio > task_q) && (best_prio > isr_top);
   assign take    = bus_rd && (au == A_ACK) && qualify;
   assign irq_out = qualify;

   intc_isr_stack #(.DEPTH(ISR_DEPTH)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (take),
      .pop       (bus_wr && au == A_EOI),
      .push_prio (best_prio),
      .top       (isr_top)
   );

   // ---------------- read mux ----------------
   logic [IW-1:0] rd_ch;

   always_comb begin
      rd_ch     = ipi_vp_hit ? IW'(ipi_vp_i) : IW'(src_off + IPI_COUNT);
      bus_rdata = '0;
      if (au == A_FEAT)       bus_rdata = {8'(VERSION), 8'd0, 16'(NUM_SRC - 1)};
      else if (au == A_GCONF) bus_rdata = {31'd0, busy};
      else if (au == A_SPUR)  bus_rdata = {24'd0, spur_q};
      else if (au == A_TASK)  bus_rdata = {{(32 - PRIO_W){1'b0}}, task_q};
      else if (au == A_ACK)   bus_rdata = {24'd0, qualify ? cfg_a[best_idx].vec : spur_q};
      else if (ipi_vp_hit || src_hit)
                              bus_rdata = pack_cfg(cfg_a[rd_ch], pend_v[rd_ch]);
   end

   // R5: the top task priority holds everything off
   assert_task_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (task_q == '1) |-> !irq_out);
   // R11: when the soft reset ends every channel is masked
   assert_reset_masks_R11: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (&mask_v));

endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;

   localparam int N = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [N-1:0] src_in = '0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [11:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_out;

   int n_tests = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   prio_intc uut (
      .clk(clk), .rst_n(rst_n), .src_in(src_in),
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_out(irq_out)
   );

   function automatic int a_src(int s);  return 32'h100 + 16 * s; endfunction
   function automatic int a_ipi(int i);  return 32'h010 + 16 * i; endfunction
   function automatic int a_disp(int i); return 32'h0C0 + 16 * i; endfunction
   localparam int A_FEAT = 0, A_GCONF = 4, A_SPUR = 8, A_TASK = 32'h80,
                  A_ACK = 32'h84, A_EOI = 32'h88, A_WHO = 32'h8C;

   function automatic logic [31:0] vp(bit m, bit lvl, bit hi, int prio, int vec);
      return {m, 1'b0, 12'd0, lvl, hi, 4'd0, 4'(prio), 8'(vec)};
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk); bus_wr = 1'b1; bus_addr = 12'(a); bus_wdata = d;
      @(negedge clk); bus_wr = 1'b0; #1;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk); bus_rd = 1'b1; bus_addr = 12'(a); #1 d = bus_rdata;
      @(negedge clk); bus_rd = 1'b0; #1;
   endtask

   task automatic step();
      @(negedge clk); #1;
   endtask

   task automatic soft_reset();
      logic [31:0] d;
      wr(A_GCONF, 32'h1);
      rd(A_GCONF, d);
      chk("R11 reset bit set", d, 32'h1);
      for (int k = 0; k < 20 && d[0]; k++) rd(A_GCONF, d);
      chk("R11 reset bit self-clears", d, 32'h0);
   endtask

   initial begin
      #(20 * 100000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      step();

      // ---- R1 reset state
      chk("R1 irq low", 32'(irq_out), 32'h0);
      for (int s = 0; s < N; s++) begin
         rd(a_src(s), d); chk("R1 source default", d, 32'h8000_0000 | s);
      end
      for (int i = 0; i < 4; i++) begin
         rd(a_ipi(i), d); chk("R1 ipi default", d, 32'h8000_0000 | (N + i));
      end
      rd(A_TASK, d); chk("R1 task 15", d, 32'd15);
      rd(A_SPUR, d); chk("R1 spurious FF", d, 32'hFF);
      rd(A_WHO, d);  chk("R1 whoami", d, 32'h0);
      rd(A_ACK, d);  chk("R7 spurious at reset", d, 32'hFF);

      // ---- R12 feature word
      rd(A_FEAT, d); chk("R12 feature", d, {8'd3, 8'd0, 16'(N - 1)});

      // ---- per-source level sweep: R2 R3 R7 R8 R13
      wr(A_TASK, 0);
      for (int s = 0; s < N; s++) begin
         wr(a_src(s), vp(0, 1, 1, s + 1, 32'h40 + s));
         rd(a_src(s), d); chk("R2 readback", d, vp(0, 1, 1, s + 1, 32'h40 + s));
         chk("R3 idle level", 32'(irq_out), 0);
         @(negedge clk); src_in[s] = 1'b1; step();
         chk("R3 level pending", 32'(irq_out), 1);
         rd(a_src(s), d); chk("R13 active bit", d, vp(0, 1, 1, s + 1, 32'h40 + s) | 32'h4000_0000);
         rd(A_ACK, d); chk("R7 ack vector", d, 32'h40 + s);
         chk("R7 held while in service", 32'(irq_out), 0);
         wr(A_EOI, 32'hDEAD_BEEF);
         chk("R8 eoi re-presents level", 32'(irq_out), 1);
         @(negedge clk); src_in[s] = 1'b0; step();
         chk("R3 level released", 32'(irq_out), 0);
         wr(a_src(s), vp(1, 1, 1, s + 1, 32'h40 + s));
         rd(a_src(s), d); chk("R2 mask visible", d[31], 1);
      end

      // ---- R5 threshold sweep
      wr(a_src(2), vp(0, 1, 1, 8, 32'h42));
      @(negedge clk); src_in[2] = 1'b1; step();
      for (int t = 0; t < 16; t++) begin
         wr(A_TASK, t);
         chk("R5 threshold", 32'(irq_out), (8 > t) ? 1 : 0);
      end
      wr(a_src(2), vp(0, 1, 1, 15, 32'h42));
      chk("R5 task 15 blocks prio 15", 32'(irq_out), 0);
      rd(A_ACK, d); chk("R7 spurious when blocked", d, 32'hFF);
      wr(A_TASK, 0);
      chk("R5 task 0 passes", 32'(irq_out), 1);
      @(negedge clk); src_in[2] = 1'b0; step();

      // ---- R6 arbitration and R7 nesting
      soft_reset();
      wr(a_src(0), vp(0, 1, 1, 5, 32'h60));
      wr(a_src(1), vp(0, 1, 1, 5, 32'h61));
      wr(a_src(2), vp(0, 1, 1, 9, 32'h62));
      wr(a_ipi(0), vp(0, 0, 0, 5, 32'h70));
      @(negedge clk); src_in[2:0] = 3'b111; step();
      wr(a_disp(0), 32'h1);
      rd(A_ACK, d); chk("R6 highest priority", d, 32'h62);
      rd(A_ACK, d); chk("R7 nothing above top", d, 32'hFF);
      @(negedge clk); src_in[2] = 1'b0; step();
      wr(A_EOI, 0);
      rd(A_ACK, d); chk("R6 ipi wins tie", d, 32'h70);
      rd(A_ACK, d); chk("R7 equal prio not nested", d, 32'hFF);
      wr(A_EOI, 0);
      rd(A_ACK, d); chk("R6 lowest index wins tie", d, 32'h60);
      @(negedge clk); src_in[0] = 1'b0; step();
      wr(A_EOI, 0);
      rd(A_ACK, d); chk("R6 next source", d, 32'h61);
      @(negedge clk); src_in[1] = 1'b0; step();
      wr(A_EOI, 0);
      chk("R8 all served", 32'(irq_out), 0);

      wr(a_src(3), vp(0, 1, 1, 3, 32'h63));
      @(negedge clk); src_in[3] = 1'b1; step();
      rd(A_ACK, d); chk("R7 low prio ack", d, 32'h63);
      chk("R7 held", 32'(irq_out), 0);
      @(negedge clk); src_in[2] = 1'b1; step();
      chk("R7 higher nests", 32'(irq_out), 1);
      rd(A_ACK, d); chk("R7 nested vector", d, 32'h62);
      @(negedge clk); src_in[2] = 1'b0; step();
      wr(A_EOI, 0);
      chk("R8 pop to outer level", 32'(irq_out), 0);
      wr(A_EOI, 0);
      chk("R8 pop to empty", 32'(irq_out), 1);
      @(negedge clk); src_in[3] = 1'b0; step();
      chk("R3 released", 32'(irq_out), 0);

      // ---- R4 R9 edge sources
      wr(a_src(5), vp(0, 0, 1, 6, 32'h55));
      @(negedge clk); src_in[5] = 1'b1; step();
      @(negedge clk); src_in[5] = 1'b0; step();
      chk("R4 edge latched", 32'(irq_out), 1);
      wr(a_src(5), vp(1, 0, 1, 6, 32'h55));
      chk("R9 masked not presented", 32'(irq_out), 0);
      rd(a_src(5), d); chk("R9 latch kept", d[30], 1);
      wr(a_src(5), vp(0, 0, 1, 6, 32'h55));
      chk("R9 unmask presents", 32'(irq_out), 1);
      rd(A_ACK, d); chk("R4 edge vector", d, 32'h55);
      rd(a_src(5), d); chk("R4 ack clears latch", d[30], 0);
      @(negedge clk); src_in[5] = 1'b1; step();
      @(negedge clk); src_in[5] = 1'b0; step();
      chk("R4 edge held during service", 32'(irq_out), 0);
      wr(A_EOI, 0);
      chk("R4 edge after eoi", 32'(irq_out), 1);
      rd(A_ACK, d); chk("R4 second edge vector", d, 32'h55);
      wr(A_EOI, 0);
      chk("R4 drained", 32'(irq_out), 0);

      // ---- R3 active-low level
      wr(a_src(6), vp(0, 1, 0, 4, 32'h66));
      chk("R3 active low pending", 32'(irq_out), 1);
      @(negedge clk); src_in[6] = 1'b1; step();
      chk("R3 active low inactive", 32'(irq_out), 0);
      wr(a_src(6), vp(1, 1, 0, 4, 32'h66));

      // ---- R10 IPI dispatch
      wr(a_ipi(1), vp(0, 0, 0, 7, 32'h81));
      wr(a_disp(1), 32'hE);
      chk("R10 bit0 clear ignored", 32'(irq_out), 0);
      rd(a_ipi(1), d); chk("R10 not pending", d, vp(0, 0, 0, 7, 32'h81));
      wr(a_disp(1), 32'h1);
      chk("R10 dispatch", 32'(irq_out), 1);
      rd(A_ACK, d); chk("R10 ipi vector", d, 32'h81);
      wr(A_EOI, 0);
      chk("R10 served", 32'(irq_out), 0);

      // ---- R7 programmable spurious, R11 reset of configuration
      wr(A_SPUR, 32'h3C);
      rd(A_ACK, d); chk("R7 programmed spurious", d, 32'h3C);
      soft_reset();
      for (int s = 0; s < N; s++) begin
         rd(a_src(s), d); chk("R11 source restored", d, 32'h8000_0000 | s);
      end

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule